// File: doc/BRIEF.md
# Posted-Write Real-Time Clock

This block is a memory-mapped real-time clock for a battery-backed domain. It keeps a 32-bit seconds count and a 15-bit sub-second count. The sub-second count advances on each pulse of a slow tick input and carries into the seconds count when it wraps. A two-word alarm compare raises a flag when the time reaches a programmed value. A control bit starts and stops timekeeping. A status register holds sticky flags that software clears by writing 1. An enable register selects which flags drive a single interrupt line.

Register writes are posted. The bus accepts a write, holds it for a fixed commit latency, and then applies it to the time domain. Software learns the outcome from the busy, next, complete and error flags. The counter does not run until its seconds word has been loaded at least once. After reset the block is in a non-valid state, and software must clear that state before it can load the time. A tamper input forces the block back into the non-valid state.

The register bus reads every cycle. `bus_rdata` shows the register that `bus_addr` selected one clock earlier.

Top module: `rtc_keeper`

## Requirements
- R1: The registers sit at word indices 0 seconds, 1 sub-second (low 15 bits), 2 alarm seconds, 3 alarm sub-second, 4 control, 5 status, 6 interrupt enable. A read returns the register selected one cycle earlier. After reset, status reads 0x202, alarm seconds reads 0xFFFFFFFF, and every other register and `irq_out` read 0.
- R2: An accepted write takes effect at the fourth clock edge after the edge that accepted it. A read captured at that fourth edge still shows the old value. Status bit 10 (busy) is 1 from acceptance until commit. Bit 9 (next) is 1 exactly when busy is 0. Bit 8 (complete) is cleared when a write is accepted and set when it commits.
- R3: A write that arrives while busy is 1 is discarded and sets status bit 7 (error). Writing 1 to bit 7 clears it, and that clearing write is itself posted.
- R4: Status bit 1 (non-valid) is 1 after reset. While it is 1, writes to the seconds and sub-second registers are dropped. Writing 1 to bits 1 and 0 together clears both bits. A cycle with `tamper_in` high sets bit 1 and bit 0 (violation).
- R5: The counter stays frozen until the seconds register has been loaded once, even while the enable bit is 1.
- R6: Control bit 3 enables counting. While it is 0, ticks have no effect.
- R7: Each tick increments the sub-second count. The step from 0x7FFF to 0 adds one to the seconds count.
- R8: Status bit 4 (alarm) sets when a tick moves the time onto the alarm seconds and sub-second values. Writing 1 to bit 4 clears it.
- R9: An alarm seconds value of 0xFFFFFFFF never sets the alarm flag.
- R10: `irq_out` is 1 one cycle after any status flag at bit 9, 8, 7 or 4 is 1 while the matching interrupt-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | 1 | Slow tick pulse, one cycle wide |
| tamper_in | input | 1 | Security violation input |
| irq_out | output | 1 | Registered interrupt |

## Verification
The bench reads a register in the very cycle its write commits and again one cycle later. A design that commits one cycle early or late fails one of the two reads. It sends a second write straight after the first and expects that write to be dropped with the error flag set. A design that queued or overwrote the pending write would change the target register instead. It loads the seconds count while the block is non-valid or tampered, and ticks a counter that was never loaded. A design that skipped these gates would move the time. It also runs the sub-second count through its wrap and sets an alarm at all-ones seconds. A wrong carry or a missing never-match guard would show as a wrong seconds value or a stray alarm.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW    = 32;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RG_SECS  = 3'd0,
    RG_FRAC  = 3'd1,
    RG_ASECS = 3'd2,
    RG_AFRAC = 3'd3,
    RG_CTRL  = 3'd4,
    RG_STAT  = 3'd5,
    RG_IEN   = 3'd6
  } reg_sel_e;

  localparam int ST_BUSY  = 10;
  localparam int ST_NEXT  = 9;
  localparam int ST_DONE  = 8;
  localparam int ST_ERR   = 7;
  localparam int ST_ALRM  = 4;
  localparam int ST_INVAL = 1;
  localparam int ST_TAMP  = 0;
  localparam int CT_RUN   = 3;

  localparam logic [DW-1:0] IEN_MASK =
    (DW'(1) << ST_NEXT) | (DW'(1) << ST_DONE) | (DW'(1) << ST_ERR) | (DW'(1) << ST_ALRM);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DW-1:0]    data;
  } wr_cmd_t;
endpackage

// File: rtl/rtc_post_queue.sv
module rtc_post_queue
  import rtc_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  wr_cmd_t req_cmd,
  output logic    busy,
  output logic    accept,
  output logic    reject,
  output logic    commit,
  output wr_cmd_t commit_cmd
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;
  logic          busy_q;
  wr_cmd_t       held;

  assign busy       = busy_q;
  assign accept     = req && !busy_q;
  assign reject     = req && busy_q;
  assign commit     = busy_q && (cnt == '0);
  assign commit_cmd = held;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      held   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt    <= CW'(LAT - 1);
      held   <= req_cmd;
    end else if (commit) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && !commit);
  // R2
  commit_frees_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);
endmodule

// File: rtl/rtc_time_base.sv
module rtc_time_base #(
  parameter int SW = 32,
  parameter int FW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run_en,
  input  logic          ld_secs,
  input  logic          ld_frac,
  input  logic [SW-1:0] ld_data,
  input  logic [SW-1:0] alm_secs,
  input  logic [FW-1:0] alm_frac,
  output logic [SW-1:0] secs,
  output logic [FW-1:0] frac,
  output logic          hit
);
  logic          armed;
  logic          adv;
  logic          carry;
  logic [FW-1:0] frac_nx;
  logic [SW-1:0] secs_nx;

  assign adv            = run_en && armed && tick && !ld_secs && !ld_frac;
  assign {carry, frac_nx} = {1'b0, frac} + 1'b1;
  assign secs_nx        = secs + SW'(carry);
  assign hit            = adv && (alm_secs != '1) &&
                          (secs_nx == alm_secs) && (frac_nx == alm_frac);

  always_ff @(posedge clk) begin
    if (rst) begin
      secs  <= '0;
      frac  <= '0;
      armed <= 1'b0;
    end else begin
      if (ld_secs) begin
        secs  <= ld_data;
        armed <= 1'b1;
      end
      if (ld_frac) frac <= ld_data[FW-1:0];
      if (adv) begin
        frac <= frac_nx;
        secs <= secs_nx;
      end
    end
  end

  // R5
  unarmed_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !ld_secs && !ld_frac) |=> $stable(frac) && $stable(secs));
  // R7
  wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && frac == '1) |=> (frac == '0) && (secs == $past(secs) + 1'b1));
  // R6
  halted_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !ld_secs && !ld_frac) |=> $stable(frac));
endmodule

// File: rtl/rtc_keeper.sv
module rtc_keeper
  import rtc_pkg::*;
#(
  parameter int FRAC_W     = 15,
  parameter int COMMIT_LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tick_in,
  input  logic          tamper_in,
  output logic          irq_out
);
  logic          busy, accept, reject, commit;
  wr_cmd_t       c_cmd;
  logic [DW-1:0] secs, alm_secs;
  logic [FRAC_W-1:0] frac, alm_frac;
  logic          run_en, hit;
  logic [DW-1:0] ien;
  logic          st_done, st_err, st_alrm, st_inval, st_tamp;
  logic          wr_stat, ld_secs, ld_frac;
  logic [DW-1:0] status;

  rtc_post_queue #(.LAT(COMMIT_LAT)) u_queue (
    .clk(clk), .rst(rst), .req(bus_we),
    .req_cmd('{sel: bus_addr, data: bus_wdata}),
    .busy(busy), .accept(accept), .reject(reject),
    .commit(commit), .commit_cmd(c_cmd)
  );

  assign wr_stat = commit && (c_cmd.sel == RG_STAT);
  assign ld_secs = commit && (c_cmd.sel == RG_SECS) && !st_inval;
  assign ld_frac = commit && (c_cmd.sel == RG_FRAC) && !st_inval;

  rtc_time_base #(.SW(DW), .FW(FRAC_W)) u_time (
    .clk(clk), .rst(rst), .tick(tick_in), .run_en(run_en),
    .ld_secs(ld_secs), .ld_frac(ld_frac), .ld_data(c_cmd.data),
    .alm_secs(alm_secs), .alm_frac(alm_frac),
    .secs(secs), .frac(frac), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_secs <= '1;
      alm_frac <= '0;
      run_en   <= 1'b0;
      ien      <= '0;
    end else if (commit) begin
      case (c_cmd.sel)
        RG_ASECS: alm_secs <= c_cmd.data;
        RG_AFRAC: alm_frac <= c_cmd.data[FRAC_W-1:0];
        RG_CTRL:  run_en   <= c_cmd.data[CT_RUN];
        RG_IEN:   ien      <= c_cmd.data & IEN_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_done  <= 1'b0;
      st_err   <= 1'b0;
      st_alrm  <= 1'b0;
      st_inval <= 1'b1;
      st_tamp  <= 1'b0;
    end else begin
      if (accept)      st_done <= 1'b0;
      else if (commit) st_done <= 1'b1;

      if (reject)                            st_err <= 1'b1;
      else if (wr_stat && c_cmd.data[ST_ERR]) st_err <= 1'b0;

      if (hit)                                 st_alrm <= 1'b1;
      else if (wr_stat && c_cmd.data[ST_ALRM]) st_alrm <= 1'b0;

      if (tamper_in) begin
        st_inval <= 1'b1;
        st_tamp  <= 1'b1;
      end else if (wr_stat) begin
        if (c_cmd.data[ST_INVAL] && c_cmd.data[ST_TAMP]) st_inval <= 1'b0;
        if (c_cmd.data[ST_TAMP]) st_tamp <= 1'b0;
      end
    end
  end

  always_comb begin
    status           = '0;
    status[ST_BUSY]  = busy;
    status[ST_NEXT]  = !busy;
    status[ST_DONE]  = st_done;
    status[ST_ERR]   = st_err;
    status[ST_ALRM]  = st_alrm;
    status[ST_INVAL] = st_inval;
    status[ST_TAMP]  = st_tamp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= |(status & ien);
      case (bus_addr)
        RG_SECS:  bus_rdata <= secs;
        RG_FRAC:  bus_rdata <= DW'(frac);
        RG_ASECS: bus_rdata <= alm_secs;
        RG_AFRAC: bus_rdata <= DW'(alm_frac);
        RG_CTRL:  bus_rdata <= DW'(run_en) << CT_RUN;
        RG_STAT:  bus_rdata <= status;
        RG_IEN:   bus_rdata <= ien;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R3
  reject_flags_chk: assert property (@(posedge clk) disable iff (rst)
    reject |=> st_err);
  // R2
  commit_done_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !accept) |=> st_done);
  // R4
  tamper_inval_chk: assert property (@(posedge clk) disable iff (rst)
    tamper_in |=> st_inval && st_tamp);
  // R4
  inval_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (st_inval && !tick_in) |=> $stable(secs));
  // R9
  never_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    (alm_secs == '1 && $stable(alm_secs) && !wr_stat) |=> !$rose(st_alrm));
endmodule

// File: tb/rtc_keeper_bench.sv
module rtc_keeper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_in = 1'b0;
  logic        tamper_in = 1'b0;
  logic        irq_out;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  rtc_keeper u_rtc_keeper (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .tamper_in(tamper_in), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic write_wait(input logic [2:0] a, input logic [31:0] d);
    bus_write(a, d);
    repeat (4) @(posedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(posedge clk);
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic t_reset;
    bus_read(3'd5, rv); chk("R1 status after reset", rv, 32'h202);
    bus_read(3'd2, rv); chk("R1 alarm seconds after reset", rv, 32'hFFFF_FFFF);
    bus_read(3'd0, rv); chk("R1 seconds after reset", rv, 32'h0);
    bus_read(3'd4, rv); chk("R1 control after reset", rv, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_invalid_drop;
    bus_write(3'd0, 32'h1234);
    bus_read(3'd5, rv); chk("R2 busy during pending write", rv & 32'h700, 32'h400);
    repeat (3) @(posedge clk);
    bus_read(3'd0, rv); chk("R4 seconds write dropped while non-valid", rv, 32'h0);
    bus_read(3'd5, rv); chk("R2 complete after commit", rv & 32'h700, 32'h300);
    write_wait(3'd5, 32'h3);
    bus_read(3'd5, rv); chk("R4 non-valid cleared", rv, 32'h300);
  endtask

  task automatic t_commit_timing;
    bus_write(3'd4, 32'h8);
    repeat (3) @(posedge clk);
    bus_read(3'd4, rv); chk("R2 old value at commit edge", rv, 32'h0);
    bus_read(3'd4, rv); chk("R2 new value after commit", rv, 32'h8);
  endtask

  task automatic t_frozen;
    tick(3);
    bus_read(3'd1, rv); chk("R5 unloaded counter frozen", rv, 32'h0);
  endtask

  task automatic t_wrap;
    write_wait(3'd1, 32'h7FFD);
    write_wait(3'd0, 32'd10);
    tick(1);
    bus_read(3'd1, rv); chk("R7 sub-second increments", rv, 32'h7FFE);
    tick(2);
    bus_read(3'd1, rv); chk("R7 sub-second wraps", rv, 32'h0);
    bus_read(3'd0, rv); chk("R7 carry into seconds", rv, 32'd11);
  endtask

  task automatic t_disable;
    write_wait(3'd4, 32'h0);
    tick(2);
    bus_read(3'd1, rv); chk("R6 no count while disabled", rv, 32'h0);
  endtask

  task automatic t_busy_error;
    bus_write(3'd4, 32'h8);
    bus_write(3'd6, 32'hFFFF_FFFF);
    repeat (4) @(posedge clk);
    bus_read(3'd5, rv); chk("R3 error and complete flags", rv & 32'h180, 32'h180);
    bus_read(3'd6, rv); chk("R3 discarded write left enable", rv, 32'h0);
    bus_read(3'd4, rv); chk("R3 first write committed", rv, 32'h8);
    write_wait(3'd5, 32'h80);
    bus_read(3'd5, rv); chk("R3 error cleared by write", rv & 32'h80, 32'h0);
  endtask

  task automatic t_alarm;
    write_wait(3'd2, 32'd11);
    write_wait(3'd3, 32'd2);
    tick(1);
    bus_read(3'd5, rv); chk("R8 no alarm before match", rv & 32'h10, 32'h0);
    tick(1);
    bus_read(3'd5, rv); chk("R8 alarm on match", rv & 32'h10, 32'h10);
    write_wait(3'd6, 32'h10);
    bus_read(3'd5, rv);
    chk("R10 irq from alarm", {31'b0, irq_out}, 32'h1);
    write_wait(3'd5, 32'h10);
    bus_read(3'd5, rv); chk("R8 alarm cleared", rv & 32'h10, 32'h0);
    chk("R10 irq drops", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_never;
    write_wait(3'd2, 32'hFFFF_FFFF);
    write_wait(3'd3, 32'd1);
    write_wait(3'd1, 32'd0);
    write_wait(3'd0, 32'hFFFF_FFFF);
    tick(1);
    bus_read(3'd1, rv); chk("R9 counter moved onto all-ones", rv, 32'h1);
    bus_read(3'd5, rv); chk("R9 no alarm at all-ones", rv & 32'h10, 32'h0);
  endtask

  task automatic t_tamper;
    @(negedge clk); tamper_in = 1'b1;
    @(posedge clk);
    @(negedge clk); tamper_in = 1'b0;
    bus_read(3'd5, rv); chk("R4 tamper sets flags", rv & 32'h3, 32'h3);
    write_wait(3'd0, 32'd5);
    bus_read(3'd0, rv); chk("R4 write dropped after tamper", rv, 32'hFFFF_FFFF);
    write_wait(3'd5, 32'h3);
    bus_read(3'd5, rv); chk("R4 flags cleared", rv & 32'h3, 32'h0);
  endtask

  task automatic t_irq_done;
    write_wait(3'd6, 32'h100);
    bus_read(3'd5, rv);
    chk("R10 irq from write complete", {31'b0, irq_out}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_invalid_drop();
    t_commit_timing();
    t_frozen();
    t_wrap();
    t_disable();
    t_busy_error();
    t_alarm();
    t_never();
    t_tamper();
    t_irq_done();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule